// File: doc/BRIEF.md
# Parallel-Port Unlock Sequence Detector

This block sits on the peripheral side of a PC parallel port. It watches the eight data lines, a one-cycle pulse that marks each new data value, and the four control lines. When the host presents a fixed seven-byte preamble, then a command byte, and then pulses the control lines from 0x4 to 0x5 and back to 0x4, the block carries out the command. The command sets or clears a connected flag. That flag enables the adapter's register-access logic elsewhere in the chip.

While the preamble runs, the block drives the upper status nibble with the three digits of the 12-bit identifier 0xB5F, one digit at a time. This lets the host probe for the chip without side effects. Once the strobe has completed, the block waits for the host's closing data write and then goes back to idle.

Top module: `unlock_det`

## Requirements
- R1: After reset, `connected` is 0 and `status_hi` is 0x0.
- R2: Each data value is accepted only on the clock edge where `data_stb` is high. The expected values are 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78, in that order, followed by any command byte. Command 0x20, once strobed, sets `connected` to 1 in the cycle after the edge at which the control lines are seen back at 0x4.
- R3: Command 0x30, once strobed, clears `connected` to 0.
- R4: Command 0x00, and any command byte other than 0x20 or 0x30, leaves `connected` unchanged.
- R5: A command is carried out only when the control lines are 0x4 on one edge, 0x5 on the next, and then 0x4 again. A 0x5 that does not follow a 0x4 has no effect.
- R6: `status_hi` reads 0xB once the 0xFF preamble byte has been accepted. It reads 0x5 once the 0x87 byte has been accepted.
- R7: `status_hi` reads 0xF while the control lines are held at 0x5 after the command byte. In every other state it reads 0x0.
- R8: A byte that does not match the expected preamble byte restarts matching from the beginning. If that byte is 0xFE, it counts as the first byte of a new attempt.
- R9: Data values that change without a `data_stb` pulse are ignored. A value repeated with two pulses counts as two bytes.
- R10: After the strobe completes, the next accepted byte returns the detector to idle, or to the first-byte-matched state if that byte is 0xFE. A new unlock can then follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 8 | Parallel data lines from the host |
| data_stb | input | 1 | One-cycle pulse marking a new data value |
| ctrl | input | 4 | Parallel control lines from the host |
| status_hi | output | 4 | Upper status nibble back to the host |
| connected | output | 1 | Register access enabled |

## Verification
The assertions check the following on every cycle:
- the status nibble only ever takes the four legal values;
- 0xF appears only when the control lines were at 0x5 on the previous edge;
- `connected` rises only with a 0x20 command and falls only with a 0x30 command, each on a control return to 0x4;
- the preamble position never moves without a data pulse.

Only the bench scenarios can show the remaining behaviour:
- the exact order of the ID digits;
- restart on a broken sequence, including the 0xFE re-entry and doubled bytes;
- the closing write that returns the detector to idle.

// File: rtl/unlock_det.sv
module unlock_det #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_in,
  input  logic          data_stb,
  input  logic [CW-1:0] ctrl,
  output logic [3:0]    status_hi,
  output logic          connected
);
  localparam logic [3:0] S_IDLE = 4'd0;
  localparam logic [3:0] S_ONE  = 4'd1;
  localparam logic [3:0] S_LAST = 4'd7;
  localparam logic [3:0] S_CMD  = 4'd8;
  localparam logic [3:0] S_HI   = 4'd9;
  localparam logic [3:0] S_DONE = 4'd10;
  localparam logic [CW-1:0] C_REST = CW'(4'h4);
  localparam logic [CW-1:0] C_STRB = CW'(4'h5);
  localparam logic [DW-1:0] FIRST  = DW'(8'hFE);

  logic [3:0]    st_q, st_d;
  logic [DW-1:0] cmd_q, cmd_d;
  logic [CW-1:0] ctrl_q;
  logic          conn_q, conn_d;

  function automatic logic [DW-1:0] pre_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    pre_byte = DW'(8'hFE);
      4'd1:    pre_byte = DW'(8'hAA);
      4'd2:    pre_byte = DW'(8'h55);
      4'd3:    pre_byte = DW'(8'h00);
      4'd4:    pre_byte = DW'(8'hFF);
      4'd5:    pre_byte = DW'(8'h87);
      default: pre_byte = DW'(8'h78);
    endcase
  endfunction

  wire [3:0] restart = (data_in == FIRST) ? S_ONE : S_IDLE;

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    conn_d = conn_q;
    if (data_stb) begin
      if (st_q < S_LAST)
        st_d = (data_in == pre_byte(st_q)) ? st_q + 4'd1 : restart;
      else if (st_q == S_LAST) begin
        st_d  = S_CMD;
        cmd_d = data_in;
      end else
        st_d = restart;
    end else begin
      case (st_q)
        S_CMD: if (ctrl == C_STRB && ctrl_q == C_REST) st_d = S_HI;
        S_HI: begin
          if (ctrl == C_REST) begin
            st_d = S_DONE;
            if (cmd_q == DW'(8'h20))      conn_d = 1'b1;
            else if (cmd_q == DW'(8'h30)) conn_d = 1'b0;
          end else if (ctrl != C_STRB)
            st_d = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cmd_q  <= '0;
      ctrl_q <= '0;
      conn_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      ctrl_q <= ctrl;
      conn_q <= conn_d;
    end
  end

  always_comb begin
    case (st_q)
      4'd5:    status_hi = 4'hB;
      4'd6:    status_hi = 4'h5;
      S_HI:    status_hi = 4'hF;
      default: status_hi = 4'h0;
    endcase
  end

  assign connected = conn_q;
endmodule

// File: rtl/unlock_det_chk.sv
module unlock_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_stb,
  input logic [3:0] ctrl,
  input logic [3:0] status_hi,
  input logic       connected,
  input logic [3:0] st_q,
  input logic [7:0] cmd_q
);
  a_r7_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status_hi inside {4'h0, 4'hB, 4'h5, 4'hF});

  a_r7_f_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    status_hi == 4'hF |-> $past(ctrl) == 4'h5);

  a_r2_rise_on_connect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connected) |-> ($past(cmd_q) == 8'h20 && $past(ctrl) == 4'h4));

  a_r3_fall_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connected) |-> ($past(cmd_q) == 8'h30 && $past(ctrl) == 4'h4));

  a_r9_hold_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(data_stb) && $past(st_q) < 4'd8) |-> st_q == $past(st_q));
endmodule

bind unlock_det unlock_det_chk chk_i (
  .clk(clk), .rst_n(rst_n), .data_stb(data_stb), .ctrl(ctrl),
  .status_hi(status_hi), .connected(connected), .st_q(st_q), .cmd_q(cmd_q)
);

// File: tb/unlock_det_tb_top.sv
module unlock_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic data_stb = 1'b0;
  logic [3:0] ctrl = 4'h4;
  logic [3:0] status_hi;
  logic connected;

  always #4 clk = ~clk;

  unlock_det dut_i (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_stb(data_stb),
    .ctrl(ctrl), .status_hi(status_hi), .connected(connected)
  );

  typedef struct {
    string      tag;
    logic [3:0] st;
    logic       cn;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic expect_now(input string tag, input logic [3:0] st, input logic cn);
    exp_t e;
    e.tag = tag; e.st = st; e.cn = cn;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); data_in = d; data_stb = 1'b1;
    @(negedge clk); data_stb = 1'b0;
  endtask

  task automatic set_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl = v;
    @(negedge clk);
  endtask

  task automatic preamble();
    send(8'hFE); send(8'hAA); send(8'h55); send(8'h00);
    send(8'hFF); send(8'h87); send(8'h78);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    preamble();
    send(cmd);
    set_ctrl(4'h4); set_ctrl(4'h5); set_ctrl(4'h4);
    send(8'hFF);
  endtask

  always begin
    @(negedge clk); #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (status_hi !== e.st || connected !== e.cn) begin
        fails++;
        $display("FAIL %s: status=%h conn=%b expected status=%h conn=%b",
                 e.tag, status_hi, connected, e.st, e.cn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 reset", 4'h0, 1'b0);

    send(8'hFE); send(8'hAA); send(8'h55); send(8'h00);
    expect_now("R7 idle-ish zero", 4'h0, 1'b0);
    send(8'hFF);
    expect_now("R6 digit B", 4'hB, 1'b0);
    send(8'h87);
    expect_now("R6 digit 5", 4'h5, 1'b0);
    send(8'h78);
    expect_now("R7 zero after 78", 4'h0, 1'b0);
    send(8'h20);
    set_ctrl(4'h4);
    expect_now("R7 zero before strobe", 4'h0, 1'b0);
    set_ctrl(4'h5);
    expect_now("R7 digit F", 4'hF, 1'b0);
    set_ctrl(4'h4);
    expect_now("R2 connect", 4'h0, 1'b1);
    send(8'hFF);
    expect_now("R10 back to idle", 4'h0, 1'b1);

    unlock(8'h00);
    expect_now("R4 neutral keeps state", 4'h0, 1'b1);
    unlock(8'h42);
    expect_now("R4 unknown cmd ignored", 4'h0, 1'b1);

    unlock(8'h30);
    expect_now("R3 release", 4'h0, 1'b0);

    preamble(); send(8'h20);
    set_ctrl(4'h6); set_ctrl(4'h5);
    expect_now("R5 no F without 4 first", 4'h0, 1'b0);
    set_ctrl(4'h4);
    expect_now("R5 no connect", 4'h0, 1'b0);
    send(8'hFF);

    send(8'hFE); send(8'hAA); send(8'h12); send(8'h55); send(8'h00); send(8'hFF);
    expect_now("R8 break restarts", 4'h0, 1'b0);
    send(8'hFE); send(8'hAA); send(8'hFE); send(8'hAA); send(8'h55); send(8'h00); send(8'hFF);
    expect_now("R8 FE re-entry", 4'hB, 1'b0);
    send(8'h00);

    send(8'hFE); send(8'hAA); send(8'hAA); send(8'h55); send(8'h00); send(8'hFF);
    expect_now("R9 doubled byte counts twice", 4'h0, 1'b0);
    send(8'hFE);
    @(negedge clk); data_in = 8'h33;
    @(negedge clk); data_in = 8'h99;
    @(negedge clk);
    send(8'hAA); send(8'h55); send(8'h00); send(8'hFF);
    expect_now("R9 unstrobed data ignored", 4'hB, 1'b0);
    send(8'h00);

    preamble(); send(8'h20);
    set_ctrl(4'h4); set_ctrl(4'h5); set_ctrl(4'h4);
    send(8'hFE);
    expect_now("R10 FE after strobe", 4'h0, 1'b1);
    send(8'hAA); send(8'h55); send(8'h00); send(8'hFF);
    expect_now("R10 new attempt proceeds", 4'hB, 1'b1);
    send(8'h87); send(8'h78); send(8'h30);
    set_ctrl(4'h4); set_ctrl(4'h5); set_ctrl(4'h4);
    expect_now("R10 second unlock releases", 4'h0, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule